// File: doc/BRIEF.md
# Dual-Port RAM with Same-Address Contention Arbitration

This block is a synchronous two-port word memory. Each side, left and right, has its own address, write data, read data, a pair of chip enables, a read/write select, an output enable and one active-low enable per byte lane. Both sides may access any word in the same clock cycle, including the same word. When both sides are selected on the same address, an arbiter gives the word to one side and pulls the other side's active-low BUSY low. While a side sees BUSY low, its writes are dropped, but its reads still complete. The default depth is 1024 words. `ADDR_W` can be raised to 16 for a 64K-word array.

A strap input picks the BUSY mode. As master, the block drives both BUSY outputs from its own arbiter and raises their output enables. As slave, it releases both BUSY outputs (enables low, values high). It then takes BUSY from the two input pins and uses them only to gate writes.

The arbiter is a three-state machine:
- `ARB_IDLE`: no side is blocked.
- `ARB_LEFT_OWNS`: the right side is blocked.
- `ARB_RIGHT_OWNS`: the left side is blocked.

Its transitions are:
- `IDLE->LEFT_OWNS`: a collision starts, and the left side arrived first or both arrived together.
- `IDLE->RIGHT_OWNS`: a collision starts, and only the right side was already holding that address.
- `LEFT_OWNS->LEFT_OWNS` and `RIGHT_OWNS->RIGHT_OWNS`: the collision persists.
- `LEFT_OWNS->IDLE` and `RIGHT_OWNS->IDLE`: the collision has cleared.

Arrival order has one-cycle resolution. A side "holds" an address when it was selected at that same address in the previous cycle. This single rule covers both cases: chip enables that arrive at different times, and addresses that come to match at different times.

Top module: `dpr_collision_ram`

## Requirements
- R1: A side is selected only when its `ce0_n` is 0 and its `ce1` is 1. An unselected side writes nothing.
- R2: Two selected sides on different addresses both complete in the same cycle, with both BUSY outputs high (master mode, no collision now or in the previous cycle).
- R3: When both sides are selected on equal addresses and exactly one of them held that address in the previous cycle, that side wins. The other side's BUSY goes low in that same cycle.
- R4: When both sides reach a collision in the same cycle with neither holding, the left side wins and the right BUSY goes low.
- R5: The loser's BUSY stays low while the collision persists. It stays low for one more cycle after the collision ends, then returns high.
- R6: A write by a side whose effective BUSY is low leaves memory unchanged. The winner's write completes.
- R7: A side whose BUSY is low still reads. Read data reflects memory contents before any write on that same clock edge.
- R8: `be_n[1]` enables bits 15:8 and `be_n[0]` enables bits 7:0, both active low. A write changes only enabled lanes. A read returns 0 in lanes that are not enabled.
- R9: Read data is registered and appears on `rdata` one cycle after the read is presented. `oe_n` high forces `rdata` to 0.
- R10: With `master` = 0, both BUSY output enables are 0 and both BUSY outputs are 1, even during a collision. A side's writes are blocked while its `busy_n_i` is 0, and its reads continue.
- R11: With `master` = 1, both BUSY output enables are 1 and the `busy_n_i` inputs have no effect on writes.
- R12: Out of reset, both BUSY outputs are high and both `rdata` buses are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| master | input | 1 | 1 = drive BUSY from the arbiter, 0 = take BUSY from the pins |
| l_ce0_n | input | 1 | Left chip enable, active low |
| l_ce1 | input | 1 | Left chip enable, active high |
| l_rd | input | 1 | Left access type: 1 read, 0 write |
| l_oe_n | input | 1 | Left output enable, active low |
| l_be_n | input | LANES | Left byte-lane enables, active low |
| l_addr | input | ADDR_W | Left word address |
| l_wdata | input | DATA_W | Left write data |
| l_rdata | output | DATA_W | Left read data |
| l_busy_n_o | output | 1 | Left BUSY driven in master mode |
| l_busy_oe | output | 1 | Left BUSY output enable |
| l_busy_n_i | input | 1 | Left BUSY from outside, used in slave mode |
| r_ce0_n | input | 1 | Right chip enable, active low |
| r_ce1 | input | 1 | Right chip enable, active high |
| r_rd | input | 1 | Right access type: 1 read, 0 write |
| r_oe_n | input | 1 | Right output enable, active low |
| r_be_n | input | LANES | Right byte-lane enables, active low |
| r_addr | input | ADDR_W | Right word address |
| r_wdata | input | DATA_W | Right write data |
| r_rdata | output | DATA_W | Right read data |
| r_busy_n_o | output | 1 | Right BUSY driven in master mode |
| r_busy_oe | output | 1 | Right BUSY output enable |
| r_busy_n_i | input | 1 | Right BUSY from outside, used in slave mode |

## Verification
The bench runs same-address races in both orders, once by staggering chip enables and once by moving one address onto the other. A design that tied the winner to a fixed side, or that judged arrival from enables alone, would show BUSY on the wrong side, and the loser's write would land in memory. It also runs a same-cycle tie, a collision lasting two cycles and the release cycle after it. An arbiter that dropped BUSY early would let a trailing write through, and one that held it too long would leave both sides blocked. The remaining cases are:
- a loser that reads the very word the winner writes on the same edge, where the old contents are expected;
- partial-lane writes and partial-lane reads, which catch lane swaps or unmasked lanes;
- slave-mode gating from the pins, and master-mode indifference to those pins, which catch a mode select inverted or ignored.

// File: rtl/dpr_pkg.sv
package dpr_pkg;

    // Ownership state of the contention arbiter.
    typedef enum logic [1:0] {
        ARB_IDLE       = 2'd0,
        ARB_LEFT_OWNS  = 2'd1,
        ARB_RIGHT_OWNS = 2'd2
    } arb_state_e;

endpackage

// File: rtl/dpr_port_front.sv
// Per-side front end: select decode, address-hold tracking, lane write gating.
module dpr_port_front #(
    parameter int ADDR_W = 10,
    parameter int LANES  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ce0_n,
    input  logic              ce1,
    input  logic              rd,
    input  logic [LANES-1:0]  be_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              busy_eff_n,
    output logic              sel,
    output logic              held,
    output logic              rd_go,
    output logic [LANES-1:0]  wr_lanes
);

    logic              prev_sel_q;
    logic [ADDR_W-1:0] prev_addr_q;

    assign sel = ~ce0_n & ce1;

    // Remember the previous cycle's selection so arrival order can be judged.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_sel_q  <= 1'b0;
            prev_addr_q <= '0;
        end else begin
            prev_sel_q  <= sel;
            prev_addr_q <= addr;
        end
    end

    assign held     = sel & prev_sel_q & (prev_addr_q == addr);
    assign rd_go    = sel & rd;
    assign wr_lanes = {LANES{sel & ~rd & busy_eff_n}} & ~be_n;

endmodule

// File: rtl/dpr_contention_fsm.sv
// Same-address contention arbiter: picks an owner and produces active-low BUSY.
module dpr_contention_fsm
    import dpr_pkg::*;
#(
    parameter int ADDR_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel_l,
    input  logic              sel_r,
    input  logic [ADDR_W-1:0] addr_l,
    input  logic [ADDR_W-1:0] addr_r,
    input  logic              held_l,
    input  logic              held_r,
    output logic              coll,
    output logic              busy_l_n,
    output logic              busy_r_n
);

    arb_state_e state_q;
    arb_state_e state_d;
    logic       right_first;

    assign coll        = sel_l & sel_r & (addr_l == addr_r);
    // Right wins a fresh collision only if it alone was already holding.
    assign right_first = held_r & ~held_l;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ARB_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ARB_IDLE: begin
                if (coll) state_d = right_first ? ARB_RIGHT_OWNS : ARB_LEFT_OWNS;
            end
            ARB_LEFT_OWNS: begin
                if (!coll) state_d = ARB_IDLE;
            end
            ARB_RIGHT_OWNS: begin
                if (!coll) state_d = ARB_IDLE;
            end
            default: state_d = ARB_IDLE;
        endcase
    end

    // Owner states keep the loser blocked, including the cycle after release.
    always_comb begin
        busy_l_n = 1'b1;
        busy_r_n = 1'b1;
        unique case (state_q)
            ARB_IDLE: begin
                if (coll) begin
                    busy_l_n = ~right_first;
                    busy_r_n = right_first;
                end
            end
            ARB_LEFT_OWNS:  busy_r_n = 1'b0;
            ARB_RIGHT_OWNS: busy_l_n = 1'b0;
            default: begin
                busy_l_n = 1'b1;
                busy_r_n = 1'b1;
            end
        endcase
    end

endmodule

// File: rtl/dpr_lane_bank.sv
// One byte lane of storage with two independent access sides.
module dpr_lane_bank #(
    parameter int ADDR_W = 10,
    parameter int LANE_W = 8,
    localparam int DEPTH = 1 << ADDR_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_l,
    input  logic              wr_r,
    input  logic              rd_l,
    input  logic              rd_r,
    input  logic              en_l,
    input  logic              en_r,
    input  logic [ADDR_W-1:0] addr_l,
    input  logic [ADDR_W-1:0] addr_r,
    input  logic [LANE_W-1:0] wd_l,
    input  logic [LANE_W-1:0] wd_r,
    output logic [LANE_W-1:0] rq_l,
    output logic [LANE_W-1:0] rq_r
);

    logic [LANE_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_l) mem[addr_l] <= wd_l;
        if (wr_r) mem[addr_r] <= wd_r;
    end

    // Registered read, old contents on a same-edge write; disabled lane reads 0.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rq_l <= '0;
            rq_r <= '0;
        end else begin
            if (rd_l) rq_l <= en_l ? mem[addr_l] : '0;
            if (rd_r) rq_r <= en_r ? mem[addr_r] : '0;
        end
    end

endmodule

// File: rtl/dpr_collision_ram.sv
// Two-port RAM with same-address arbitration and master/slave BUSY handling.
module dpr_collision_ram
    import dpr_pkg::*;
#(
    parameter int ADDR_W = 10,
    parameter int LANE_W = 8,
    parameter int LANES  = 2,
    localparam int DATA_W = LANE_W * LANES
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              master,
    input  logic              l_ce0_n,
    input  logic              l_ce1,
    input  logic              l_rd,
    input  logic              l_oe_n,
    input  logic [LANES-1:0]  l_be_n,
    input  logic [ADDR_W-1:0] l_addr,
    input  logic [DATA_W-1:0] l_wdata,
    output logic [DATA_W-1:0] l_rdata,
    output logic              l_busy_n_o,
    output logic              l_busy_oe,
    input  logic              l_busy_n_i,
    input  logic              r_ce0_n,
    input  logic              r_ce1,
    input  logic              r_rd,
    input  logic              r_oe_n,
    input  logic [LANES-1:0]  r_be_n,
    input  logic [ADDR_W-1:0] r_addr,
    input  logic [DATA_W-1:0] r_wdata,
    output logic [DATA_W-1:0] r_rdata,
    output logic              r_busy_n_o,
    output logic              r_busy_oe,
    input  logic              r_busy_n_i
);

    logic              coll;
    logic              arb_l_busy_n, arb_r_busy_n;
    logic              l_eff_busy_n, r_eff_busy_n;
    logic              l_sel, r_sel, l_held, r_held, l_rd_go, r_rd_go;
    logic [LANES-1:0]  l_wr_lanes, r_wr_lanes;
    logic [DATA_W-1:0] l_rq, r_rq;

    dpr_port_front #(.ADDR_W(ADDR_W), .LANES(LANES)) u_front_l (
        .clk(clk), .rst_n(rst_n), .ce0_n(l_ce0_n), .ce1(l_ce1), .rd(l_rd),
        .be_n(l_be_n), .addr(l_addr), .busy_eff_n(l_eff_busy_n),
        .sel(l_sel), .held(l_held), .rd_go(l_rd_go), .wr_lanes(l_wr_lanes)
    );

    dpr_port_front #(.ADDR_W(ADDR_W), .LANES(LANES)) u_front_r (
        .clk(clk), .rst_n(rst_n), .ce0_n(r_ce0_n), .ce1(r_ce1), .rd(r_rd),
        .be_n(r_be_n), .addr(r_addr), .busy_eff_n(r_eff_busy_n),
        .sel(r_sel), .held(r_held), .rd_go(r_rd_go), .wr_lanes(r_wr_lanes)
    );

    dpr_contention_fsm #(.ADDR_W(ADDR_W)) u_arb (
        .clk(clk), .rst_n(rst_n), .sel_l(l_sel), .sel_r(r_sel),
        .addr_l(l_addr), .addr_r(r_addr), .held_l(l_held), .held_r(r_held),
        .coll(coll), .busy_l_n(arb_l_busy_n), .busy_r_n(arb_r_busy_n)
    );

    // Master: own arbiter gates writes and drives the pins. Slave: pins gate writes.
    assign l_eff_busy_n = master ? arb_l_busy_n : l_busy_n_i;
    assign r_eff_busy_n = master ? arb_r_busy_n : r_busy_n_i;
    assign l_busy_n_o   = master ? arb_l_busy_n : 1'b1;
    assign r_busy_n_o   = master ? arb_r_busy_n : 1'b1;
    assign l_busy_oe    = master;
    assign r_busy_oe    = master;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        dpr_lane_bank #(.ADDR_W(ADDR_W), .LANE_W(LANE_W)) u_bank (
            .clk(clk), .rst_n(rst_n),
            .wr_l(l_wr_lanes[g]), .wr_r(r_wr_lanes[g]),
            .rd_l(l_rd_go), .rd_r(r_rd_go),
            .en_l(~l_be_n[g]), .en_r(~r_be_n[g]),
            .addr_l(l_addr), .addr_r(r_addr),
            .wd_l(l_wdata[g*LANE_W +: LANE_W]), .wd_r(r_wdata[g*LANE_W +: LANE_W]),
            .rq_l(l_rq[g*LANE_W +: LANE_W]), .rq_r(r_rq[g*LANE_W +: LANE_W])
        );
    end

    assign l_rdata = l_oe_n ? '0 : l_rq;
    assign r_rdata = r_oe_n ? '0 : r_rq;

endmodule

// File: rtl/dpr_collision_ram_chk.sv
// Temporal checks on the arbiter's BUSY outputs, bound into the top module.
module dpr_collision_ram_chk (
    input logic clk,
    input logic rst_n,
    input logic master,
    input logic coll,
    input logic l_busy_n_o,
    input logic r_busy_n_o
);

    logic past_ok;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) past_ok <= 1'b0;
        else        past_ok <= 1'b1;
    end

    assert_one_loser_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (master && coll) |-> ($countones({~l_busy_n_o, ~r_busy_n_o}) == 1));

    assert_quiet_no_collision_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && master && $past(master) && !coll && !$past(coll))
            |-> (l_busy_n_o && r_busy_n_o));

    assert_left_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && master && $past(master) && $past(coll) && !$past(l_busy_n_o))
            |-> !l_busy_n_o);

    assert_right_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && master && $past(master) && $past(coll) && !$past(r_busy_n_o))
            |-> !r_busy_n_o);

    assert_owner_stable_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && master && $past(master) && coll && $past(coll) && $past(l_busy_n_o))
            |-> l_busy_n_o);

endmodule

bind dpr_collision_ram dpr_collision_ram_chk u_chk (
    .clk(clk), .rst_n(rst_n), .master(master), .coll(coll),
    .l_busy_n_o(l_busy_n_o), .r_busy_n_o(r_busy_n_o)
);

// File: tb/dpr_collision_ram_bench.sv
module dpr_collision_ram_bench;

    localparam int AW = 10;
    localparam int DW = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic master = 1'b1;
    logic l_ce0_n = 1'b1, l_ce1 = 1'b0, l_rd = 1'b1, l_oe_n = 1'b0;
    logic r_ce0_n = 1'b1, r_ce1 = 1'b0, r_rd = 1'b1, r_oe_n = 1'b0;
    logic [1:0] l_be_n = 2'b11, r_be_n = 2'b11;
    logic [AW-1:0] l_addr = '0, r_addr = '0;
    logic [DW-1:0] l_wdata = '0, r_wdata = '0;
    logic [DW-1:0] l_rdata, r_rdata;
    logic l_busy_n_o, l_busy_oe, r_busy_n_o, r_busy_oe;
    logic l_busy_n_i = 1'b1, r_busy_n_i = 1'b1;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #5 clk = ~clk;

    dpr_collision_ram #(.ADDR_W(AW)) u_dpr_collision_ram (
        .clk(clk), .rst_n(rst_n), .master(master),
        .l_ce0_n(l_ce0_n), .l_ce1(l_ce1), .l_rd(l_rd), .l_oe_n(l_oe_n), .l_be_n(l_be_n),
        .l_addr(l_addr), .l_wdata(l_wdata), .l_rdata(l_rdata),
        .l_busy_n_o(l_busy_n_o), .l_busy_oe(l_busy_oe), .l_busy_n_i(l_busy_n_i),
        .r_ce0_n(r_ce0_n), .r_ce1(r_ce1), .r_rd(r_rd), .r_oe_n(r_oe_n), .r_be_n(r_be_n),
        .r_addr(r_addr), .r_wdata(r_wdata), .r_rdata(r_rdata),
        .r_busy_n_o(r_busy_n_o), .r_busy_oe(r_busy_oe), .r_busy_n_i(r_busy_n_i)
    );

    task automatic check(input string rq, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", rq, act, exp);
        end
    endtask

    // p = 0 left, 1 right
    task automatic drv(input bit p, input logic c0n, input logic c1, input logic rd,
                       input logic [1:0] ben, input logic [AW-1:0] a, input logic [DW-1:0] d);
        if (!p) begin
            l_ce0_n = c0n; l_ce1 = c1; l_rd = rd; l_be_n = ben; l_addr = a; l_wdata = d;
        end else begin
            r_ce0_n = c0n; r_ce1 = c1; r_rd = rd; r_be_n = ben; r_addr = a; r_wdata = d;
        end
    endtask

    task automatic idle(input bit p);
        drv(p, 1'b1, 1'b0, 1'b1, 2'b11, '0, '0);
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic wr_word(input bit p, input logic [AW-1:0] a, input logic [DW-1:0] d);
        drv(p, 1'b0, 1'b1, 1'b0, 2'b00, a, d);
        tick();
        idle(p);
    endtask

    task automatic rd_word(input bit p, input logic [AW-1:0] a, output logic [DW-1:0] v);
        drv(p, 1'b0, 1'b1, 1'b1, 2'b00, a, '0);
        tick();
        v = p ? r_rdata : l_rdata;
        idle(p);
    endtask

    task automatic settle();
        idle(1'b0); idle(1'b1);
        tick(); tick();
    endtask

    task automatic sc_reset();
        #1;
        check("R12 left busy", {15'd0, l_busy_n_o}, 16'd1);
        check("R12 right busy", {15'd0, r_busy_n_o}, 16'd1);
        check("R12 left rdata", l_rdata, 16'h0000);
        check("R12 right rdata", r_rdata, 16'h0000);
    endtask

    task automatic sc_select();
        logic [DW-1:0] v;
        wr_word(1'b0, 10'd70, 16'hCAFE);
        drv(1'b0, 1'b0, 1'b0, 1'b0, 2'b00, 10'd70, 16'hDEAD);
        tick();
        drv(1'b0, 1'b1, 1'b1, 1'b0, 2'b00, 10'd70, 16'hBEEF);
        tick();
        idle(1'b0);
        rd_word(1'b0, 10'd70, v);
        check("R1 unselected writes ignored", v, 16'hCAFE);
    endtask

    task automatic sc_diff_addr();
        logic [DW-1:0] v;
        drv(1'b0, 1'b0, 1'b1, 1'b0, 2'b00, 10'd60, 16'h1234);
        drv(1'b1, 1'b0, 1'b1, 1'b0, 2'b00, 10'd61, 16'h5678);
        #1;
        check("R2 no busy, different addresses", {14'd0, l_busy_n_o, r_busy_n_o}, 16'd3);
        tick();
        idle(1'b0); idle(1'b1);
        rd_word(1'b0, 10'd60, v);
        check("R2 left write done", v, 16'h1234);
        rd_word(1'b1, 10'd61, v);
        check("R2 right write done", v, 16'h5678);
    endtask

    task automatic sc_ce_left_first();
        logic [DW-1:0] v;
        wr_word(1'b0, 10'd10, 16'h1111);
        drv(1'b0, 1'b0, 1'b1, 1'b1, 2'b00, 10'd10, '0);
        tick();
        drv(1'b1, 1'b0, 1'b1, 1'b0, 2'b00, 10'd10, 16'h2222);
        #1;
        check("R3 left first: busy l/r", {14'd0, l_busy_n_o, r_busy_n_o}, 16'd2);
        tick();
        #1;
        check("R5 busy held while colliding", {15'd0, r_busy_n_o}, 16'd0);
        check("R9 winner read data", l_rdata, 16'h1111);
        idle(1'b0); idle(1'b1);
        #1;
        check("R5 busy held one cycle after", {15'd0, r_busy_n_o}, 16'd0);
        tick();
        #1;
        check("R5 busy released", {15'd0, r_busy_n_o}, 16'd1);
        rd_word(1'b0, 10'd10, v);
        check("R6 loser write blocked", v, 16'h1111);
    endtask

    task automatic sc_ce_right_first();
        logic [DW-1:0] v;
        wr_word(1'b0, 10'd20, 16'h3333);
        drv(1'b1, 1'b0, 1'b1, 1'b1, 2'b00, 10'd20, '0);
        tick();
        drv(1'b0, 1'b0, 1'b1, 1'b0, 2'b00, 10'd20, 16'h4444);
        #1;
        check("R3 right first: busy l/r", {14'd0, l_busy_n_o, r_busy_n_o}, 16'd1);
        tick();
        check("R9 right winner read", r_rdata, 16'h3333);
        settle();
        rd_word(1'b1, 10'd20, v);
        check("R6 left loser write blocked", v, 16'h3333);
    endtask

    task automatic sc_tie();
        logic [DW-1:0] v;
        drv(1'b0, 1'b0, 1'b1, 1'b0, 2'b00, 10'd30, 16'h8888);
        drv(1'b1, 1'b0, 1'b1, 1'b0, 2'b00, 10'd30, 16'h9999);
        #1;
        check("R4 tie goes left", {14'd0, l_busy_n_o, r_busy_n_o}, 16'd2);
        tick();
        settle();
        rd_word(1'b0, 10'd30, v);
        check("R4 R6 winner write kept", v, 16'h8888);
    endtask

    task automatic sc_addr_order();
        logic [DW-1:0] v;
        wr_word(1'b0, 10'd40, 16'h0E0E);
        drv(1'b0, 1'b0, 1'b1, 1'b1, 2'b00, 10'd41, '0);
        drv(1'b1, 1'b0, 1'b1, 1'b1, 2'b00, 10'd40, '0);
        #1;
        check("R2 both enabled, addresses differ", {14'd0, l_busy_n_o, r_busy_n_o}, 16'd3);
        tick();
        drv(1'b0, 1'b0, 1'b1, 1'b0, 2'b00, 10'd40, 16'hAAAA);
        #1;
        check("R3 address arrival: right wins", {14'd0, l_busy_n_o, r_busy_n_o}, 16'd1);
        tick();
        check("R7 winner read during race", r_rdata, 16'h0E0E);
        settle();
        rd_word(1'b1, 10'd40, v);
        check("R6 late-address write blocked", v, 16'h0E0E);
    endtask

    task automatic sc_loser_read();
        wr_word(1'b0, 10'd50, 16'h5555);
        drv(1'b0, 1'b0, 1'b1, 1'b1, 2'b00, 10'd50, '0);
        tick();
        drv(1'b0, 1'b0, 1'b1, 1'b0, 2'b00, 10'd50, 16'h7777);
        drv(1'b1, 1'b0, 1'b1, 1'b1, 2'b00, 10'd50, '0);
        #1;
        check("R3 right loses to held left", {15'd0, r_busy_n_o}, 16'd0);
        tick();
        check("R7 loser read sees old data", r_rdata, 16'h5555);
        tick();
        check("R7 loser read sees winner write", r_rdata, 16'h7777);
        settle();
    endtask

    task automatic sc_lanes();
        logic [DW-1:0] v;
        wr_word(1'b0, 10'd80, 16'hA5C3);
        drv(1'b0, 1'b0, 1'b1, 1'b0, 2'b01, 10'd80, 16'h7B99);
        tick();
        drv(1'b0, 1'b0, 1'b1, 1'b0, 2'b10, 10'd80, 16'h0011);
        tick();
        drv(1'b0, 1'b0, 1'b1, 1'b1, 2'b10, 10'd80, '0);
        tick();
        check("R8 lower-lane read masks upper", l_rdata, 16'h0011);
        drv(1'b0, 1'b0, 1'b1, 1'b1, 2'b01, 10'd80, '0);
        tick();
        check("R8 upper-lane read masks lower", l_rdata, 16'h7B00);
        idle(1'b0);
        rd_word(1'b0, 10'd80, v);
        check("R8 lane-merged word", v, 16'h7B11);
    endtask

    task automatic sc_output_timing();
        drv(1'b0, 1'b0, 1'b1, 1'b1, 2'b00, 10'd70, '0);
        #1;
        check("R9 read data one cycle late", l_rdata, 16'h7B11);
        tick();
        check("R9 new read data", l_rdata, 16'hCAFE);
        idle(1'b0);
        l_oe_n = 1'b1;
        #1;
        check("R9 oe_n high forces zero", l_rdata, 16'h0000);
        l_oe_n = 1'b0;
        #1;
        check("R9 oe_n low restores data", l_rdata, 16'hCAFE);
    endtask

    task automatic sc_slave();
        logic [DW-1:0] v;
        master = 1'b0;
        #1;
        check("R10 slave releases busy", {12'd0, l_busy_oe, r_busy_oe, l_busy_n_o, r_busy_n_o}, 16'h0003);
        wr_word(1'b0, 10'd90, 16'h1111);
        l_busy_n_i = 1'b0;
        drv(1'b0, 1'b0, 1'b1, 1'b0, 2'b00, 10'd90, 16'hBEEF);
        tick();
        rd_word(1'b0, 10'd90, v);
        check("R10 pin busy blocks write, read continues", v, 16'h1111);
        l_busy_n_i = 1'b1;
        drv(1'b0, 1'b0, 1'b1, 1'b1, 2'b00, 10'd90, '0);
        drv(1'b1, 1'b0, 1'b1, 1'b0, 2'b00, 10'd90, 16'h2222);
        #1;
        check("R10 no busy driven in slave collision", {14'd0, l_busy_n_o, r_busy_n_o}, 16'd3);
        tick();
        settle();
        rd_word(1'b0, 10'd90, v);
        check("R10 slave write with pin high", v, 16'h2222);
        master = 1'b1;
        settle();
    endtask

    task automatic sc_master_pins();
        logic [DW-1:0] v;
        l_busy_n_i = 1'b0;
        r_busy_n_i = 1'b0;
        #1;
        check("R11 master drives busy", {12'd0, l_busy_oe, r_busy_oe, l_busy_n_o, r_busy_n_o}, 16'h000F);
        wr_word(1'b0, 10'd100, 16'h0F0F);
        wr_word(1'b1, 10'd101, 16'hF0F0);
        rd_word(1'b0, 10'd100, v);
        check("R11 left pin ignored", v, 16'h0F0F);
        rd_word(1'b1, 10'd101, v);
        check("R11 right pin ignored", v, 16'hF0F0);
        l_busy_n_i = 1'b1;
        r_busy_n_i = 1'b1;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        sc_reset();
        tick();
        sc_select();
        sc_diff_addr();
        sc_ce_left_first();
        settle();
        sc_ce_right_first();
        settle();
        sc_tie();
        sc_addr_order();
        sc_loser_read();
        sc_lanes();
        sc_output_timing();
        settle();
        sc_slave();
        sc_master_pins();
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule